// File: doc/BRIEF.md
# Framebuffer Scanout Fetcher

This block streams a framebuffer out of memory for a display pipeline. On each frame-start pulse it latches a base address, a line width in pixels, a pixel depth, a line count and a replication setting. It then walks the picture as a flat run of 128-bit words, one line after another. Each line can be fetched several times in a row, so that a downstream pixel stage can show the picture at an integer vertical scale without any line store of its own.

Read requests go to a memory port through a valid/ready handshake. Read data comes back on a separate response-valid channel, in the order the requests were made, and is queued in a deep FIFO. The pixel stage drains that FIFO through a second valid/ready pair. A credit count of the reads still in flight keeps the FIFO from ever being asked to hold more than it can, which lets memory answer slowly for a while without starving the display. Every request carries a small frame tag. After a restart, data still on its way from the previous frame is dropped instead of being shown.

Back-pressure rules: `req_valid` depends only on internal state. Once it is raised it stays high, with a stable address and tag, until `req_ready` is seen, unless a frame start intervenes. The pixel side may hold `pix_ready` low for as long as it likes; fetching simply pauses once the credits run out.

Top module: `scanout_fetch`

## Requirements
- R1: After reset, `req_valid`, `pix_valid` and `underflow` are low, and no request is made until the first `frame_start`.
- R2: A line takes ceil(`cfg_width` * `cfg_bpp` / 128) words. Word k of line n is read at byte address base + (n * words_per_line + k) * 16.
- R3: Each line's full address run is issued `cfg_rep` + 1 times in a row before the next line starts.
- R4: A frame issues exactly `cfg_lines` * (`cfg_rep` + 1) * words_per_line requests. After that, `req_valid` stays low until the next `frame_start`.
- R5: `req_valid` is high only when FIFO occupancy plus outstanding reads is below `DEPTH`, and some of the frame's requests are still unissued.
- R6: While `req_valid` is high and `req_ready` is low, the request stays valid on the next cycle with the same address and tag, unless `frame_start` was high.
- R7: Responses whose `rsp_tag` equals the current frame tag are queued. `pix_valid` is high exactly when the queue is non-empty, and `pix_data` presents the queued words in arrival order.
- R8: In the cycle after `frame_start`, the FIFO is empty and the next request address is `cfg_base`. A request accepted, or a response arriving, in the `frame_start` cycle itself belongs to the old frame.
- R9: `underflow` becomes set in the cycle after one in which `pix_ready` is high while `pix_valid` is low. It stays set until the cycle after the next `frame_start`, which clears it.
- R10: `req_tag` counts frame starts modulo 2^`TAG_W`, starting at 0 after reset. A response carrying any other tag is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Byte address of the first word (16-byte aligned) |
| cfg_width | input | WID_W | Pixels per line |
| cfg_bpp | input | BPP_W | Bits per pixel |
| cfg_lines | input | LINE_W | Source lines per frame |
| cfg_rep | input | REP_W | Extra reads of each line (0 = read once) |
| frame_start | input | 1 | Restart pulse; samples the cfg inputs |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address of the 128-bit word |
| req_tag | output | TAG_W | Frame tag of the request |
| rsp_valid | input | 1 | Read data valid |
| rsp_tag | input | TAG_W | Tag returned with the data |
| rsp_data | input | DATA_W | Read data |
| pix_valid | output | 1 | FIFO holds a word |
| pix_ready | input | 1 | Pixel stage takes or demands a word |
| pix_data | output | DATA_W | Head word of the FIFO |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The assertions assume that memory answers only for reads that are still outstanding and answers them in request order. They also assume that `frame_start` is a single-cycle pulse whose configuration stays steady across the sampling edge. The bench's memory model keeps to these rules by holding accepted requests in a queue and returning them from the front after a random delay. Configuration is changed only away from the edge that samples it. Within those rules the stimulus varies the ready rates, the latency and the pixel demand, and it restarts a frame while reads are still in flight.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  // Words of the memory port needed to hold one line, rounded up.
  function automatic int unsigned words_per_line(int unsigned width_px, int unsigned bpp,
                                                 int unsigned word_bits);
    return (width_px * bpp + word_bits - 1) / word_bits;
  endfunction
endpackage

// File: rtl/sfa_walker.sv
module sfa_walker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int WID_W  = 12,
  parameter int BPP_W  = 6,
  parameter int LINE_W = 12,
  parameter int REP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [BPP_W-1:0]  cfg_bpp,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [REP_W-1:0]  cfg_rep,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  localparam int SHIFT = $clog2(DATA_W / 8);
  localparam int WPL_W = WID_W + BPP_W + 1;

  logic [WPL_W-1:0]  wpl_calc, wpl_q, word_q;
  logic [REP_W-1:0]  rep_q, rep_lim_q;
  logic [LINE_W-1:0] line_q, line_lim_q;
  logic [ADDR_W-1:0] line_base_q, stride_q;
  logic              last_word, last_rep, last_line;

  assign wpl_calc  = WPL_W'(sfa_pkg::words_per_line(32'(cfg_width), 32'(cfg_bpp), DATA_W));
  assign last_word = (word_q == wpl_q - WPL_W'(1));
  assign last_rep  = (rep_q == rep_lim_q);
  assign last_line = (line_q == line_lim_q - LINE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      addr        <= '0;
      line_base_q <= '0;
      stride_q    <= '0;
      wpl_q       <= '0;
      word_q      <= '0;
      rep_q       <= '0;
      rep_lim_q   <= '0;
      line_q      <= '0;
      line_lim_q  <= '0;
    end else if (start) begin
      busy        <= (cfg_lines != '0) && (wpl_calc != '0);
      addr        <= cfg_base;
      line_base_q <= cfg_base;
      stride_q    <= ADDR_W'(wpl_calc) << SHIFT;
      wpl_q       <= wpl_calc;
      word_q      <= '0;
      rep_q       <= '0;
      rep_lim_q   <= cfg_rep;
      line_q      <= '0;
      line_lim_q  <= cfg_lines;
    end else if (advance && busy) begin
      if (!last_word) begin
        word_q <= word_q + WPL_W'(1);
        addr   <= addr + ADDR_W'(DATA_W / 8);
      end else begin
        word_q <= '0;
        if (!last_rep) begin
          rep_q <= rep_q + REP_W'(1);
          addr  <= line_base_q;
        end else begin
          rep_q <= '0;
          if (last_line) begin
            busy <= 1'b0;
          end else begin
            line_q      <= line_q + LINE_W'(1);
            line_base_q <= line_base_q + stride_q;
            addr        <= line_base_q + stride_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfa_fifo.sv
module sfa_fifo #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
      if (rd_en) rd_ptr <= rd_ptr + PTR_W'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfa_credit.sv
module sfa_credit #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  input  logic [CNT_W-1:0] fifo_cnt,
  output logic [CNT_W-1:0] outst,
  output logic             can_issue
);
  logic [CNT_W:0] committed;

  assign committed = {1'b0, fifo_cnt} + {1'b0, outst};
  assign can_issue = committed < (CNT_W + 1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= '0;
    end else begin
      case ({issue, retire})
        2'b10:   outst <= outst + CNT_W'(1);
        2'b01:   outst <= outst - CNT_W'(1);
        default: outst <= outst;
      endcase
    end
  end
endmodule

// File: rtl/scanout_fetch.sv
module scanout_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int WID_W  = 12,
  parameter int BPP_W  = 6,
  parameter int LINE_W = 12,
  parameter int REP_W  = 3,
  parameter int DEPTH  = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [BPP_W-1:0]  cfg_bpp,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [REP_W-1:0]  cfg_rep,
  input  logic              frame_start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [DATA_W-1:0] pix_data,
  output logic              underflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             busy, can_issue, accept, fifo_wr, fifo_rd, fifo_empty;
  logic [CNT_W-1:0] fifo_cnt, outst;
  logic [TAG_W-1:0] frame_tag;

  assign req_valid = busy && can_issue;
  assign accept    = req_valid && req_ready;
  assign req_tag   = frame_tag;
  assign fifo_wr   = rsp_valid && (rsp_tag == frame_tag) && !frame_start;
  assign pix_valid = !fifo_empty;
  assign fifo_rd   = pix_valid && pix_ready && !frame_start;

  sfa_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WID_W(WID_W),
    .BPP_W(BPP_W), .LINE_W(LINE_W), .REP_W(REP_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .advance   (accept),
    .cfg_base  (cfg_base),
    .cfg_width (cfg_width),
    .cfg_bpp   (cfg_bpp),
    .cfg_lines (cfg_lines),
    .cfg_rep   (cfg_rep),
    .busy      (busy),
    .addr      (req_addr)
  );

  sfa_credit #(.DEPTH(DEPTH)) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (accept),
    .retire    (rsp_valid),
    .fifo_cnt  (fifo_cnt),
    .outst     (outst),
    .can_issue (can_issue)
  );

  sfa_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (frame_start),
    .wr_en   (fifo_wr),
    .wr_data (rsp_data),
    .rd_en   (fifo_rd),
    .rd_data (pix_data),
    .count   (fifo_cnt),
    .empty   (fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_tag <= '0;
      underflow <= 1'b0;
    end else if (frame_start) begin
      frame_tag <= frame_tag + TAG_W'(1);
      underflow <= 1'b0;
    end else if (pix_ready && fifo_empty) begin
      underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [TAG_W-1:0]  req_tag,
  input logic [ADDR_W-1:0] cfg_base,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              underflow,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [CNT_W-1:0]  outst
);
  // R5: queued words plus reads in flight never exceed the FIFO depth
  p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_cnt} + {1'b0, outst}) <= (CNT_W + 1)'(DEPTH));

  // R6: a stalled request holds
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !frame_start |=> req_valid && $stable(req_addr) && $stable(req_tag));

  // R8: restart lands on the base and empties the queue
  p_restart_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> req_addr == $past(cfg_base));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !pix_valid);

  // R10: the tag steps once per frame start
  p_tag_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> req_tag == TAG_W'($past(req_tag) + 1'b1));

  // R9: starvation flag set, held and cleared
  p_uf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready && !pix_valid && !frame_start |=> underflow);
  p_uf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !frame_start |=> underflow);
  p_uf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !underflow);
endmodule

bind scanout_fetch sfa_checker #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_tag     (req_tag),
  .cfg_base    (cfg_base),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .underflow   (underflow),
  .fifo_cnt    (fifo_cnt),
  .outst       (outst)
);

// File: tb/tb_scanout_fetch.sv
module tb_scanout_fetch;
  localparam int DEPTH = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cfg_base = '0;
  logic [11:0]  cfg_width = '0;
  logic [5:0]   cfg_bpp = '0;
  logic [11:0]  cfg_lines = '0;
  logic [2:0]   cfg_rep = '0;
  logic         frame_start = 1'b0;
  logic         req_valid, req_ready = 1'b0;
  logic [31:0]  req_addr;
  logic [1:0]   req_tag;
  logic         rsp_valid = 1'b0;
  logic [1:0]   rsp_tag = '0;
  logic [127:0] rsp_data = '0;
  logic         pix_valid, pix_ready = 1'b0;
  logic [127:0] pix_data;
  logic         underflow;

  scanout_fetch dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit running = 0, fs_req = 0, finished = 0;
  int ready_pct = 100, pix_pct = 0, lat_max = 1;

  logic [31:0]  mq_addr[$];
  logic [1:0]   mq_tag[$];
  int           mq_due[$];
  logic [31:0]  ex_addr[$];
  logic [127:0] rf[$];
  int           outst = 0;
  logic [1:0]   ctag = '0;
  logic         ruf = 1'b0;
  bit           prev_hold = 0, prev_fs = 0;
  logic [31:0]  prev_addr = '0;

  function automatic logic [127:0] mkdata(logic [31:0] a, logic [1:0] t);
    return {a, a ^ 32'hA5A5_5A5A, ~a, 30'd0, t};
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      bit exp_rv, hs, pop;
      // compare against the model
      exp_rv = (ex_addr.size() > 0) && (rf.size() + outst < DEPTH);
      check(req_valid === exp_rv, "R4/R5", "req_valid", 128'(req_valid), 128'(exp_rv));
      if (exp_rv && req_valid) begin
        check(req_addr === ex_addr[0], "R2/R3", "req_addr", 128'(req_addr), 128'(ex_addr[0]));
        check(req_tag === ctag, "R10", "req_tag", 128'(req_tag), 128'(ctag));
      end
      check(pix_valid === (rf.size() > 0), "R7", "pix_valid", 128'(pix_valid), 128'(rf.size() > 0));
      if (pix_valid && rf.size() > 0)
        check(pix_data === rf[0], "R7", "pix_data", pix_data, rf[0]);
      check(underflow === ruf, "R9", "underflow", 128'(underflow), 128'(ruf));
      if (prev_hold)
        check(req_valid && req_addr === prev_addr, "R6", "held request", 128'(req_addr), 128'(prev_addr));
      if (prev_fs)
        check(!pix_valid, "R8", "flushed pix_valid", 128'(pix_valid), 128'(0));

      // drive the next inputs
      req_ready = ($urandom % 100) < ready_pct;
      pix_ready = ($urandom % 100) < pix_pct;
      frame_start = fs_req;
      fs_req = 0;
      if (mq_addr.size() > 0 && mq_due[0] <= cyc) begin
        rsp_valid = 1'b1;
        rsp_tag   = mq_tag[0];
        rsp_data  = mkdata(mq_addr[0], mq_tag[0]);
        void'(mq_addr.pop_front()); void'(mq_tag.pop_front()); void'(mq_due.pop_front());
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end

      // model the coming edge
      hs  = req_valid && req_ready;
      pop = pix_valid && pix_ready && !frame_start;
      if (hs) begin
        mq_addr.push_back(req_addr);
        mq_tag.push_back(req_tag);
        mq_due.push_back(cyc + 1 + int'($urandom % lat_max));
        outst++;
        if (!frame_start && ex_addr.size() > 0) void'(ex_addr.pop_front());
      end
      if (pop) void'(rf.pop_front());
      if (rsp_valid) begin
        outst--;
        if (!frame_start && rsp_tag == ctag) rf.push_back(rsp_data);
      end
      if (frame_start) ruf = 1'b0;
      else if (pix_ready && !pix_valid) ruf = 1'b1;
      if (frame_start) begin
        int wpl;
        rf.delete();
        ex_addr.delete();
        ctag = ctag + 2'd1;
        wpl = (int'(cfg_width) * int'(cfg_bpp) + 127) / 128;
        for (int l = 0; l < int'(cfg_lines); l++)
          for (int r = 0; r <= int'(cfg_rep); r++)
            for (int w = 0; w < wpl; w++)
              ex_addr.push_back(cfg_base + 32'((l * wpl + w) * 16));
      end
      prev_hold = req_valid && !req_ready && !frame_start;
      prev_addr = req_addr;
      prev_fs   = frame_start;
      cyc++;
    end
  end

  task automatic start_frame(logic [31:0] b, int w, int bpp, int lines, int rep);
    @(posedge clk); #2;
    cfg_base = b; cfg_width = 12'(w); cfg_bpp = 6'(bpp);
    cfg_lines = 12'(lines); cfg_rep = 3'(rep);
    fs_req = 1;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic wait_idle();
    while (ex_addr.size() != 0 || outst != 0 || rf.size() != 0 || mq_addr.size() != 0)
      @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    running = 1;
    repeat (6) @(posedge clk); #2;
    // R1: quiet after reset with no frame started
    check(!req_valid, "R1", "req_valid after reset", 128'(req_valid), 128'(0));
    check(!pix_valid, "R1", "pix_valid after reset", 128'(pix_valid), 128'(0));
    check(!underflow, "R1", "underflow after reset", 128'(underflow), 128'(0));

    // Straight run, two words per line, one read per line
    pix_pct = 100;
    start_frame(32'h0000_1000, 20, 8, 3, 0);
    wait_idle();

    // One word per line, three reads per line, slow memory
    ready_pct = 60; pix_pct = 70; lat_max = 6;
    start_frame(32'h0002_0000, 7, 1, 4, 2);
    wait_idle();

    // R5: stalled pixel stage fills the FIFO to its credit limit
    pix_pct = 0; ready_pct = 100; lat_max = 3;
    start_frame(32'h0004_0000, 100, 32, 2, 1);
    repeat (300) @(posedge clk); #2;
    check(!req_valid, "R5", "no request when full", 128'(req_valid), 128'(0));
    check(pix_valid, "R5", "queue holds data", 128'(pix_valid), 128'(1));
    pix_pct = 100;
    wait_idle();
    #2;
    check(!req_valid, "R4", "frame finished", 128'(req_valid), 128'(0));

    // R8/R10: restart mid-frame with reads in flight, then round-up width
    ready_pct = 80; pix_pct = 60; lat_max = 8;
    start_frame(32'h0008_0000, 1920, 8, 1080, 0);
    repeat (200) @(posedge clk);
    start_frame(32'h0010_0000, 9, 16, 5, 3);
    wait_idle();

    // Deepest replication
    ready_pct = 70; pix_pct = 85; lat_max = 5;
    start_frame(32'h0020_0000, 640, 4, 3, 7);
    wait_idle();

    // Back-to-back restarts wrap the tag
    start_frame(32'h0030_0000, 64, 8, 2, 0);
    start_frame(32'h0031_0000, 64, 8, 2, 1);
    wait_idle();

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule